// File: doc/BRIEF.md
# Mailbox Interrupt Flags for a Dual-Port Memory

This block generates one interrupt flag for each side of a two-port memory. Each side owns one mailbox word at the top of the address space. The left side owns the second-highest address. The right side owns the highest address. When a side writes into the mailbox owned by the other side, the flag of the owner is raised. The owner lowers its flag by accessing its own mailbox with output enable active. The level of its read/write line does not matter for this clear. The mailbox words stay plain 9-bit storage in the memory array, which lies outside this block. The block only watches the control and address lines of both sides.

Both sides present their strobes to the block as synchronous, active-low signals, and the block samples them on the rising clock edge. Each side also presents a busy input from the arbitration logic. While a side sees busy, the block ignores every set or clear that the access from that side would cause. The interrupt outputs are active low and come straight from registers, so each output is always driven to a defined level. Handshakes play no part: every pin is a plain level sampled once per clock.

Top module: `mbx_irq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `irq_l_n` and `irq_r_n` are both 1 (no interrupt pending).
- R2: A right-side write is `r_sel_n`=0 together with `r_wr_n`=0. A right-side write to address 2^ADDR_W-2 (0x7FE by default) with `r_busy_n`=1 drives `irq_l_n` to 0 after the next rising edge.
- R3: A left-side write is `l_sel_n`=0 together with `l_wr_n`=0. A left-side write to address 2^ADDR_W-1 (0x7FF by default) with `l_busy_n`=1 drives `irq_r_n` to 0 after the next rising edge.
- R4: A clearing access needs select and output enable both low, with any `*_wr_n` level. A left clearing access at 0x7FE drives `irq_l_n` to 1 after the next edge. A right clearing access at 0x7FF drives `irq_r_n` to 1 after the next edge. Both clears require the accessing side's busy input to be 1.
- R5: The following leave both flags unchanged:
  - an owner access with output enable high, or with select high;
  - a read by the other side;
  - a write by the owner into its own mailbox;
  - any access to an address that is not a mailbox.
- R6: When the accessing side's busy input is 0, a set or clear it would cause is ignored. The busy input of the other side has no effect on that access.
- R7: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R8: Without a qualifying set or clear, each flag holds its value. Repeated sets or clears of a flag already in that state change nothing. Both outputs are always 0 or 1, never X or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left side select, active low |
| l_oe_n | input | 1 | Left side output enable, active low |
| l_wr_n | input | 1 | Left side write strobe, 0 = write |
| l_addr | input | ADDR_W | Left side address |
| l_busy_n | input | 1 | Left side busy from arbitration, active low |
| r_sel_n | input | 1 | Right side select, active low |
| r_oe_n | input | 1 | Right side output enable, active low |
| r_wr_n | input | 1 | Right side write strobe, 0 = write |
| r_addr | input | ADDR_W | Right side address |
| r_busy_n | input | 1 | Right side busy from arbitration, active low |
| irq_l_n | output | 1 | Left interrupt, active low |
| irq_r_n | output | 1 | Right interrupt, active low |

## Verification
The bench targets several corner cases:
- A set and a clear in the same cycle. A design that gives the clear priority would lose the message.
- Busy asserted on the side that is not accessing. A design that decodes busy from the wrong side would block a legal set or clear.
- A clear access with the write strobe low. A design that treats only reads as clears would leave the flag stuck.
- An owner access with output enable high, and an owner writing into its own mailbox. A design with loose decoding would clear or set a flag by mistake.

A behavioural model runs beside the design for a long random phase. That phase focuses on the top two addresses and occasionally asserts busy.

// File: rtl/mbx_irq_pkg.sv
`timescale 1ns/1ps
package mbx_irq_pkg;
  // Side indices used to select ports and flags.
  typedef enum int unsigned {SIDE_LEFT = 0, SIDE_RIGHT = 1} side_e;
  localparam int unsigned NUM_SIDES = 2;

  // Active-low control strobes of one side, grouped.
  typedef struct packed {
    logic sel_n;
    logic oe_n;
    logic wr_n;
    logic busy_n;
  } port_ctl_t;

  function automatic int unsigned peer_of(input int unsigned side);
    return (NUM_SIDES - 1) - side;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
`timescale 1ns/1ps
// Decodes one side's access into two requests:
//   post_peer : a write into the mailbox owned by the other side
//   ack_own   : a clearing access to this side's own mailbox
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              post_peer,
  output logic              ack_own
);
  logic selected;
  logic granted;
  logic at_own;
  logic at_peer;

  always_comb begin
    selected  = ~ctl.sel_n;
    granted   = ctl.busy_n;
    at_own    = (addr == OWN_BOX);
    at_peer   = (addr == PEER_BOX);
    post_peer = selected & ~ctl.wr_n & at_peer & granted;
    ack_own   = selected & ~ctl.oe_n & at_own & granted;
  end
endmodule

// File: rtl/mbx_flag_cell.sv
`timescale 1ns/1ps
// One interrupt flag, stored active low. Set has priority over clear.
module mbx_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic irq_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_n_q <= 1'b1;
    else if (set_req) irq_n_q <= 1'b0;
    else if (clr_req) irq_n_q <= 1'b1;
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_oe_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_sel_n,
  input  logic              r_oe_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  // Highest address; the left mailbox sits one below it, the right one at it.
  localparam int unsigned TOP_ADDR = (1 << ADDR_W) - 1;

  port_ctl_t         ctl   [NUM_SIDES];
  logic [ADDR_W-1:0] addr  [NUM_SIDES];
  logic              post  [NUM_SIDES];
  logic              ack   [NUM_SIDES];
  logic              irq_n [NUM_SIDES];

  assign ctl[SIDE_LEFT]   = '{sel_n: l_sel_n, oe_n: l_oe_n, wr_n: l_wr_n, busy_n: l_busy_n};
  assign ctl[SIDE_RIGHT]  = '{sel_n: r_sel_n, oe_n: r_oe_n, wr_n: r_wr_n, busy_n: r_busy_n};
  assign addr[SIDE_LEFT]  = l_addr;
  assign addr[SIDE_RIGHT] = r_addr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int unsigned P = peer_of(s);
    localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(TOP_ADDR - 1 + s);
    localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(TOP_ADDR - 1 + P);

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN_BOX),
      .PEER_BOX(PEER_BOX)
    ) u_dec (
      .ctl      (ctl[s]),
      .addr     (addr[s]),
      .post_peer(post[s]),
      .ack_own  (ack[s])
    );

    // The flag owned by side s is raised by the peer and lowered by s itself.
    mbx_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(post[P]),
      .clr_req(ack[s]),
      .irq_n  (irq_n[s])
    );
  end

  assign irq_l_n = irq_n[SIDE_LEFT];
  assign irq_r_n = irq_n[SIDE_RIGHT];
endmodule

// File: rtl/mbx_irq_chk.sv
`timescale 1ns/1ps
module mbx_irq_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sel_n,
  input logic              l_oe_n,
  input logic              l_wr_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_n,
  input logic              r_sel_n,
  input logic              r_oe_n,
  input logic              r_wr_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n,
  input logic              irq_l_n,
  input logic              irq_r_n
);
  localparam logic [ADDR_W-1:0] BOX_R = '1;
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic set_l, set_r, clr_l, clr_r, blocked_set_l;
  assign set_l = !r_sel_n && !r_wr_n && r_addr == BOX_L && r_busy_n;
  assign set_r = !l_sel_n && !l_wr_n && l_addr == BOX_R && l_busy_n;
  assign clr_l = !l_sel_n && !l_oe_n && l_addr == BOX_L && l_busy_n;
  assign clr_r = !r_sel_n && !r_oe_n && r_addr == BOX_R && r_busy_n;
  assign blocked_set_l = !r_sel_n && !r_wr_n && r_addr == BOX_L && !r_busy_n;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_l_n && irq_r_n));
  assert_set_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> !irq_l_n);
  assert_set_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> !irq_r_n);
  assert_clear_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> irq_l_n);
  assert_clear_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> irq_r_n);
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_set_l && !clr_l) |=> $stable(irq_l_n));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r && clr_r) |=> !irq_r_n);
  assert_hold_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l && !clr_l) |=> $stable(irq_l_n));
  assert_hold_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r && !clr_r) |=> $stable(irq_r_n));
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_bench.sv
`timescale 1ns/1ps
module mbx_irq_bench;
  localparam int AW = 11;
  localparam logic [AW-1:0] MB_L = 11'h7FE;
  localparam logic [AW-1:0] MB_R = 11'h7FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel_n = 1, l_oe_n = 1, l_wr_n = 1, l_busy_n = 1;
  logic r_sel_n = 1, r_oe_n = 1, r_wr_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic irq_l_n, irq_r_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference flags: 1 means interrupt pending.
  bit m_l, m_r;

  always #4 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u_mbx_irq (.*);

  // Behavioural reference, following the requirements directly.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_l <= 0; m_r <= 0;
    end else begin
      bit rw_l, lw_r, lc, rc;
      rw_l = (r_sel_n === 0) && (r_wr_n === 0) && (r_addr === MB_L) && (r_busy_n === 1);
      lw_r = (l_sel_n === 0) && (l_wr_n === 0) && (l_addr === MB_R) && (l_busy_n === 1);
      lc   = (l_sel_n === 0) && (l_oe_n === 0) && (l_addr === MB_L) && (l_busy_n === 1);
      rc   = (r_sel_n === 0) && (r_oe_n === 0) && (r_addr === MB_R) && (r_busy_n === 1);
      if (rw_l) m_l <= 1; else if (lc) m_l <= 0;
      if (lw_r) m_r <= 1; else if (rc) m_r <= 0;
    end
  end

  task automatic check_bit(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  // Compare with the model, away from the active edge.
  task automatic cmp_model(string tag);
    check_bit(tag, "irq_l_n(model)", irq_l_n, ~m_l);
    check_bit(tag, "irq_r_n(model)", irq_r_n, ~m_r);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic expect_out(string tag, logic el, logic er);
    check_bit(tag, "irq_l_n", irq_l_n, el);
    check_bit(tag, "irq_r_n", irq_r_n, er);
  endtask

  task automatic idle();
    l_sel_n = 1; l_oe_n = 1; l_wr_n = 1; l_busy_n = 1; l_addr = '0;
    r_sel_n = 1; r_oe_n = 1; r_wr_n = 1; r_busy_n = 1; r_addr = '0;
  endtask

  task automatic drv_l(logic s, logic o, logic w, logic b, logic [AW-1:0] a);
    l_sel_n = s; l_oe_n = o; l_wr_n = w; l_busy_n = b; l_addr = a;
  endtask

  task automatic drv_r(logic s, logic o, logic w, logic b, logic [AW-1:0] a);
    r_sel_n = s; r_oe_n = o; r_wr_n = w; r_busy_n = b; r_addr = a;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset
    repeat (3) @(negedge clk);
    expect_out("R1", 1, 1);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1", 1, 1);

    // R2: right writes left mailbox
    drv_r(0, 1, 0, 1, MB_L); step("R2"); expect_out("R2", 0, 1);
    // R8: repeated set and idle hold
    step("R8"); expect_out("R8", 0, 1);
    idle(); step("R8"); step("R8"); expect_out("R8", 0, 1);

    // R5: owner access without OE, or without select
    drv_l(0, 1, 1, 1, MB_L); step("R5"); expect_out("R5", 0, 1);
    drv_l(1, 0, 1, 1, MB_L); step("R5"); expect_out("R5", 0, 1);
    // R4: clear with read level, then with write level
    drv_l(0, 0, 1, 1, MB_L); step("R4"); expect_out("R4", 1, 1);
    step("R8"); expect_out("R8", 1, 1);
    idle(); drv_r(0, 1, 0, 1, MB_L); step("R2"); expect_out("R2", 0, 1);
    idle(); drv_l(0, 0, 0, 1, MB_L); step("R4"); expect_out("R4", 1, 1);

    // R3 and right clear (R4)
    idle(); drv_l(0, 1, 0, 1, MB_R); step("R3"); expect_out("R3", 1, 0);
    idle(); drv_r(0, 0, 1, 1, MB_R); step("R4"); expect_out("R4", 1, 1);

    // R5: read by other side, owner writing own box, other addresses
    idle(); drv_r(0, 0, 1, 1, MB_L); step("R5"); expect_out("R5", 1, 1);
    idle(); drv_l(0, 0, 0, 1, MB_L); drv_r(0, 0, 0, 1, MB_R); step("R5"); expect_out("R5", 1, 1);
    idle(); drv_l(0, 1, 0, 1, 11'h7FD); drv_r(0, 1, 0, 1, 11'h3FE); step("R5"); expect_out("R5", 1, 1);

    // R6: busy on writer blocks set; busy on other side does not
    idle(); drv_r(0, 1, 0, 0, MB_L); step("R6"); expect_out("R6", 1, 1);
    idle(); drv_r(0, 1, 0, 1, MB_L); l_busy_n = 0; step("R6"); expect_out("R6", 0, 1);
    idle(); drv_l(0, 0, 1, 0, MB_L); step("R6"); expect_out("R6", 0, 1);
    idle(); drv_l(0, 0, 1, 1, MB_L); r_busy_n = 0; step("R6"); expect_out("R6", 1, 1);

    // R7: set and clear together, from clear and from set state
    idle(); drv_r(0, 1, 0, 1, MB_L); drv_l(0, 0, 1, 1, MB_L); step("R7"); expect_out("R7", 0, 1);
    step("R7"); expect_out("R7", 0, 1);
    idle(); drv_l(0, 1, 0, 1, MB_R); drv_r(0, 0, 1, 1, MB_R); step("R7"); expect_out("R7", 0, 0);

    // R1: reset in mid-run clears both flags
    idle(); rst_n = 0; @(negedge clk); expect_out("R1", 1, 1);
    rst_n = 1; @(negedge clk); expect_out("R1", 1, 1);

    // R8: random traffic around the mailboxes against the model
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] la, ra;
      case ($urandom_range(3))
        0: la = MB_L; 1: la = MB_R; 2: la = 11'h7FD; default: la = AW'($urandom);
      endcase
      case ($urandom_range(3))
        0: ra = MB_L; 1: ra = MB_R; 2: ra = 11'h7FD; default: ra = AW'($urandom);
      endcase
      drv_l(logic'($urandom_range(3) == 0), logic'($urandom_range(1)), logic'($urandom_range(1)),
            logic'($urandom_range(7) != 0), la);
      drv_r(logic'($urandom_range(3) == 0), logic'($urandom_range(1)), logic'($urandom_range(1)),
            logic'($urandom_range(7) != 0), ra);
      step("R8");
      check_bit("R8", "irq_l_n known", logic'(!$isunknown(irq_l_n)), 1'b1);
    end
    idle();
    step("R8");
    summary();
  end
endmodule